// File: doc/BRIEF.md
# Message Identifier Acceptance Filter Bank

This block decides, frame by frame, whether a received message identifier should be kept. It holds a small bank of filters. Each filter is a mask word and a reference identifier word. A filter matches when the masked incoming identifier equals the masked reference. A per-filter enable register selects which filters take part in the decision. When at least one filter is enabled, a frame is kept only if some enabled filter matches. When no filter is enabled, every frame is kept.

The receive path presents each 32-bit identifier word with a one-cycle valid strobe. One clock later the block raises exactly one of two single-cycle pulses: keep or drop. The storage stage downstream uses that pulse to push the frame or discard it.

Software reaches the filter registers and a status word over a simple word-addressed register bus. Reads are combinational. Writes take effect at the clock edge. A filter's mask and reference can only be rewritten while that filter is disabled and no decision is pending; any other write to them is silently dropped.

Top module: `id_filter_bank`

## Requirements
- R1: After reset, all enables, masks and reference words read 0, the status word reads 0, and neither result pulse is high.
- R2: A filter matches when `((idWord ^ reference) & mask) == 0`, which is the same as `(idWord & mask) == (reference & mask)`.
- R3: With one or more filters enabled, a strobed identifier gives the keep pulse if any enabled filter matches. It gives the drop pulse if none of them matches. Disabled filters never cause a keep.
- R4: With the enable register at 0, every strobed identifier gives the keep pulse, whatever its value and whatever the mask and reference contents.
- R5: Register map by word address: 0 = enable register, with filter k enabled by bit k (bits 0 to 3 for filters 0 to 3); 1 = status (read-only); 2+2k = mask of filter k; 3+2k = reference of filter k. Written values read back at the same address. Enable writes are always taken.
- R6: A write to the mask or reference of a filter whose enable bit is set is ignored, and the register keeps its old value. After the filter is disabled, the same write is taken.
- R7: Status bit 11 is the busy flag. It reads 1 in the clock cycle that follows an identifier strobe, while the decision is being issued, and reads 0 once no decision is pending. Mask or reference writes made while busy reads 1 are ignored.
- R8: Exactly one of keep/drop pulses in the cycle after each strobe, for one cycle only. Neither pulses in a cycle that does not follow a strobe.
- R9: The whole identifier word takes part in the comparison. The word carries the 11-bit base identifier in bits 31:21, the substitute-remote bit at 20, the extension flag at 19, the 18-bit extended identifier in bits 18:1 and the remote-request bit at 0. A mask of 0xFFE00000 therefore compares the base identifier only, and a mask of 0x00000001 compares only the remote-request bit.
- R10: Strobes on back-to-back cycles each produce their own decision, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Word address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| idValid | input | 1 | Identifier strobe, one cycle per frame |
| idWord | input | ID_W | Received identifier word |
| keepPulse | output | 1 | Frame accepted, one cycle after the strobe |
| dropPulse | output | 1 | Frame rejected, one cycle after the strobe |

## Verification
The bench builds the block with its defaults: four filters, a 5-bit address and a 32-bit identifier. With these values every address in the map is reachable, up to the reference word of the last filter at address 9. This lets the bench mix the first and the last filter in one decision. It tests base-only masks, remote-bit-only masks, locked and unlocked writes, writes that land during the busy cycle, and strobes issued on back-to-back cycles.

// File: rtl/filt_pkg.sv
package filt_pkg;
  localparam int BUSY_BIT = 11;
  localparam int MAP_BASE = 2;

  typedef struct packed {
    logic       wrMask;
    logic       wrRef;
    logic       wrEnable;
    logic       sample;
    logic [7:0] slot;
  } filtStrobe_t;
endpackage

// File: rtl/filt_ctrl.sv
module filt_ctrl
  import filt_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                idValid,
  input  logic [NUM_FILT-1:0] enVec,
  output filtStrobe_t         strb,
  output logic                busy
);
  localparam int LAST_ADDR = MAP_BASE + 2 * NUM_FILT;

  logic [31:0] addrExt;
  logic        inFilt;
  logic [7:0]  slotIdx;
  logic        slotOn;
  logic        locked;

  assign addrExt = 32'(regAddr);
  assign inFilt  = (addrExt >= 32'(MAP_BASE)) && (addrExt < 32'(LAST_ADDR));
  assign slotIdx = 8'((addrExt - 32'(MAP_BASE)) >> 1);

  always_comb begin
    slotOn = 1'b0;
    for (int k = 0; k < NUM_FILT; k++) begin
      if (slotIdx == 8'(k)) slotOn = enVec[k];
    end
  end

  assign locked = slotOn || busy;

  always_comb begin
    strb          = '0;
    strb.slot     = slotIdx;
    strb.sample   = idValid;
    strb.wrEnable = regWe && (addrExt == 32'd0);
    strb.wrMask   = regWe && inFilt && !regAddr[0] && !locked;
    strb.wrRef    = regWe && inFilt &&  regAddr[0] && !locked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= idValid;
  end

  p_busy_after_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    idValid |=> busy);
  p_busy_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |=> !busy);
  p_no_write_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.wrMask || strb.wrRef));
endmodule

// File: rtl/filt_datapath.sv
module filt_datapath
  import filt_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int ADDR_W   = 5,
  parameter int ID_W     = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  filtStrobe_t         strb,
  input  logic [31:0]         regWdata,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                busy,
  input  logic [ID_W-1:0]     idWord,
  output logic [NUM_FILT-1:0] enVec,
  output logic                decision,
  output logic [31:0]         regRdata
);
  logic [ID_W-1:0]     maskR [NUM_FILT];
  logic [ID_W-1:0]     refR  [NUM_FILT];
  logic [NUM_FILT-1:0] hit;
  logic [31:0]         addrExt;

  assign addrExt = 32'(regAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enVec <= '0;
    else if (strb.wrEnable) enVec <= regWdata[NUM_FILT-1:0];
  end

  for (genvar k = 0; k < NUM_FILT; k++) begin : g_filt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskR[k] <= '0;
        refR[k]  <= '0;
      end else begin
        if (strb.wrMask && strb.slot == 8'(k)) maskR[k] <= ID_W'(regWdata);
        if (strb.wrRef  && strb.slot == 8'(k)) refR[k]  <= ID_W'(regWdata);
      end
    end

    assign hit[k] = ((idWord ^ refR[k]) & maskR[k]) == '0;

    p_mask_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
      enVec[k] |=> $stable(maskR[k]));
    p_ref_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
      enVec[k] |=> $stable(refR[k]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            decision <= 1'b0;
    else if (strb.sample) decision <= (enVec == '0) || |(hit & enVec);
  end

  always_comb begin
    regRdata = '0;
    if (addrExt == 32'd0) regRdata = 32'(enVec);
    if (addrExt == 32'd1) regRdata[BUSY_BIT] = busy;
    for (int k = 0; k < NUM_FILT; k++) begin
      if (addrExt == 32'(MAP_BASE + 2 * k))     regRdata = 32'(maskR[k]);
      if (addrExt == 32'(MAP_BASE + 2 * k + 1)) regRdata = 32'(refR[k]);
    end
  end

  p_accept_all_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sample && enVec == '0) |=> decision);
endmodule

// File: rtl/id_filter_bank.sv
module id_filter_bank
  import filt_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int ADDR_W   = 5,
  parameter int ID_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              idValid,
  input  logic [ID_W-1:0]   idWord,
  output logic              keepPulse,
  output logic              dropPulse
);
  filtStrobe_t         strb;
  logic                busy;
  logic                decision;
  logic [NUM_FILT-1:0] enVec;

  filt_ctrl #(.NUM_FILT(NUM_FILT), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .idValid(idValid), .enVec(enVec), .strb(strb), .busy(busy)
  );

  filt_datapath #(.NUM_FILT(NUM_FILT), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .regAddr(regAddr), .busy(busy), .idWord(idWord), .enVec(enVec),
    .decision(decision), .regRdata(regRdata)
  );

  assign keepPulse = busy &&  decision;
  assign dropPulse = busy && !decision;

  p_one_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({keepPulse, dropPulse}));
  p_result_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    idValid |=> (keepPulse || dropPulse));
endmodule

// File: tb/id_filter_bank_test.sv
module id_filter_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        idValid = 1'b0;
  logic [31:0] idWord = '0;
  logic        keepPulse, dropPulse;
  int          checks = 0;
  int          errs = 0;

  id_filter_bank uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .idValid(idValid),
    .idWord(idWord), .keepPulse(keepPulse), .dropPulse(dropPulse)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(string tag, logic [4:0] a, logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 chk(tag, regRdata, exp);
  endtask

  // Strobe one identifier; check the pulse pair in the following cycle.
  task automatic send(string tag, logic [31:0] id, logic keepExp);
    @(negedge clk);
    idValid = 1'b1; idWord = id;
    @(negedge clk);
    idValid = 1'b0;
    chk(tag, {30'd0, keepPulse, dropPulse}, {30'd0, keepExp, !keepExp});
    @(negedge clk);
    chk({tag, " R8 idle"}, {30'd0, keepPulse, dropPulse}, 32'd0);
  endtask

  task automatic t_reset;
    rd("R1 enable", 5'd0, 32'd0);
    rd("R1 status", 5'd1, 32'd0);
    rd("R1 mask0", 5'd2, 32'd0);
    rd("R1 ref3", 5'd9, 32'd0);
    chk("R1 pulses", {30'd0, keepPulse, dropPulse}, 32'd0);
  endtask

  task automatic t_accept_all;
    send("R4 none enabled a", 32'h1234_5678, 1'b1);
    send("R4 none enabled b", 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_base_match;
    wr(5'd2, 32'hFFE0_0000);
    wr(5'd3, 32'h123 << 21);
    rd("R5 mask readback", 5'd2, 32'hFFE0_0000);
    wr(5'd0, 32'd1);
    send("R2 R9 base match", (32'h123 << 21) | 32'h0005_A5A5, 1'b1);
    send("R3 base mismatch", (32'h124 << 21), 1'b0);
  endtask

  task automatic t_two_filters;
    wr(5'd0, 32'd0);
    wr(5'd8, 32'h0000_0001);
    wr(5'd9, 32'h0000_0001);
    wr(5'd0, 32'd9);
    rd("R5 enable readback", 5'd0, 32'd9);
    send("R3 R9 rtr filter3", (32'h555 << 21) | 32'd1, 1'b1);
    send("R3 no enabled match", (32'h555 << 21), 1'b0);
    wr(5'd0, 32'd8);
    send("R3 disabled filter0 ignored", (32'h123 << 21), 1'b0);
  endtask

  task automatic t_locked;
    wr(5'd0, 32'd9);
    wr(5'd2, 32'h0000_0000);
    rd("R6 locked mask", 5'd2, 32'hFFE0_0000);
    wr(5'd3, 32'hDEAD_BEEF);
    rd("R6 locked ref", 5'd3, 32'h123 << 21);
    wr(5'd0, 32'd8);
    wr(5'd2, 32'hFFFF_FFFF);
    rd("R6 unlocked mask", 5'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_busy;
    @(negedge clk);
    idValid = 1'b1; idWord = 32'd1;
    @(negedge clk);
    idValid = 1'b0;
    regAddr = 5'd1;
    regWe = 1'b1; regAddr = 5'd4; regWdata = 32'h0000_AAAA;
    #1 chk("R7 keep during busy", {31'd0, keepPulse}, 32'd1);
    regWe = 1'b0; regAddr = 5'd1;
    #0.5 chk("R7 busy bit11", regRdata, 32'h0000_0800);
    regWe = 1'b1; regAddr = 5'd4;
    @(negedge clk);
    regWe = 1'b0;
    rd("R7 write while busy dropped", 5'd4, 32'd0);
    rd("R7 busy clear", 5'd1, 32'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    idValid = 1'b1; idWord = 32'd1;
    @(negedge clk);
    idWord = 32'd0;
    chk("R10 first keep", {30'd0, keepPulse, dropPulse}, 32'd2);
    @(negedge clk);
    idValid = 1'b0;
    chk("R10 second drop", {30'd0, keepPulse, dropPulse}, 32'd1);
    @(negedge clk);
    chk("R10 R8 quiet", {30'd0, keepPulse, dropPulse}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_accept_all();
    t_base_match();
    t_two_filters();
    t_locked();
    t_busy();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errs++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule